// File: doc/BRIEF.md
# Power-Domain Startup Sequencer

This controller powers up a microcontroller's supply domains one at a time. A cold start first waits out a power-on interval. A wakeup from deep sleep goes straight to the first powered stage. From there the chain runs through these stages:

- the reference stage;
- the regulator stage;
- one retention-switch stage for each SRAM bank that is still selected, taken in ascending bank order;
- three power-switch stages;
- the oscillator stage.

Reset release is raised only after the oscillator stage finishes. Each stage lasts a programmable number of clock cycles. A bank whose deselect bit is set gets no stage at all, so startup gets shorter as banks are removed.

Once the chain is up, it can be dropped to its off state, but only under two conditions. The CPU must enter one of the two deepest sleep modes. The radio domain must also be deselected or asleep. When that happens, every domain enable and the reset release fall in the same cycle. A wake request then restarts the chain. The block shows its stage code, the stage's sub-index and a busy flag, so an environment can follow the sequence and time it.

Top module: `pwr_chain_seq`

## Requirements
- R1: While `rst_n` is low, the block is in the power-on stage: `stage` = 1, `busy` = 1, `rst_release` = 0, and every domain enable is 0.
- R2: Stage codes are 0 off, 1 power-on, 2 reference, 3 regulator, 4 SRAM switch, 5 power switch, 6 oscillator, 7 running. `stage_idx` gives the bank or switch number in stages 4 and 5 and is 0 in every other stage. A cold start visits 1, 2, 3, then 4 once for each selected bank in ascending index, then 5 with index 0, 1 and 2, then 6, then 7.
- R3: Each stage lasts exactly its programmed count in rising edges, and a count of 0 acts as 1. After `rst_n` rises, `rst_release` is high after t_por + t_ref + t_reg + N·t_sram + 3·t_psw + t_osc rising edges, where N is the number of selected banks.
- R4: Bit i of `sram_off` deselects bank i. A deselected bank gets no stage 4 visit, and its `sram_sw_en` bit never rises.
- R5: Each domain enable rises when its stage begins and stays high until shutdown. In stage 7, `ref_en`, `reg_en` and `osc_en` are high, and `sram_sw_en` equals the complement of `sram_off`.
- R6: Power switch 0 feeds the radio. If `radio_off` is high when that stage begins, `psw_en[0]` stays 0, but the stage is still timed.
- R7: While running, `sleep_en` with `sleep_mode` 3'b010 or 3'b011 may cut the chain. Every other mode code keeps it running.
- R8: Even in those two modes, the chain is cut only if `radio_off` or `radio_sleep` is high.
- R9: A cut takes effect on the next rising edge. In that same cycle, `stage` becomes 0, and `rst_release`, `busy` and every domain enable go low.
- R10: In stage 0, a sampled `wake_req` skips the power-on stage and enters stage 2. `rst_release` is high after 1 + t_ref + t_reg + N·t_sram + 3·t_psw + t_osc rising edges, counting the edge that samples the request.
- R11: `wake_req` has no effect outside stage 0, and a sleep request has no effect outside stage 7. Pulsing either one during startup or while running changes neither the stage nor the startup time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| wake_req | input | 1 | Request to restart the chain from the off state |
| sleep_en | input | 1 | CPU is entering the sleep mode on `sleep_mode` |
| sleep_mode | input | 3 | CPU sleep mode code |
| sram_off | input | NUM_BANKS | Per-bank deselect bits |
| radio_off | input | 1 | Radio domain deselected |
| radio_sleep | input | 1 | Radio is in its sleep state |
| t_por | input | CNT_W | Power-on stage length in cycles |
| t_ref | input | CNT_W | Reference stage length |
| t_reg | input | CNT_W | Regulator stage length |
| t_sram | input | CNT_W | Length of each bank-switch stage |
| t_psw | input | CNT_W | Length of each power-switch stage |
| t_osc | input | CNT_W | Oscillator stage length |
| ref_en | output | 1 | Reference domain enable |
| reg_en | output | 1 | Regulator enable |
| sram_sw_en | output | NUM_BANKS | Bank retention-switch enables |
| psw_en | output | NUM_PSW | Power-switch enables, index 0 is the radio |
| osc_en | output | 1 | Oscillator enable |
| rst_release | output | 1 | Reset release, high once the chain is complete |
| busy | output | 1 | A startup stage is in progress |
| stage | output | 3 | Current stage code |
| stage_idx | output | IDX_W | Bank or switch index of the current stage |

## Verification
The chain is run with several bank masks: all selected, alternating bits, a single bank, and none selected. Comparing the measured release time and the recorded stage trace against the formula separates a skipped bank from a merely shortened one, and it exposes any misordered stage. The radio switch is tested with the radio both selected and deselected, which shows that a gated switch still takes its full time slot. The cut condition is swept over all eight mode codes and over active, asleep and deselected radio states, so that a gate on the mode alone can be told apart from one that also checks the radio. Wake and sleep pulses are injected during startup, and a zero stage count is loaded, to catch requests leaking into the wrong state and counts being mishandled.

// File: rtl/pwr_chain_pkg.sv
package pwr_chain_pkg;

  typedef enum logic [2:0] {
    ST_OFF  = 3'd0,
    ST_POR  = 3'd1,
    ST_REF  = 3'd2,
    ST_REG  = 3'd3,
    ST_SRAM = 3'd4,
    ST_PSW  = 3'd5,
    ST_OSC  = 3'd6,
    ST_RUN  = 3'd7
  } stage_e;

  localparam logic [2:0] SM_PDOWN = 3'b010;
  localparam logic [2:0] SM_PSAVE = 3'b011;

  // Width of an index that can address either a bank or a power switch.
  function automatic int idx_width(input int banks, input int switches);
    int w;
    w = (banks > switches) ? $clog2(banks) : $clog2(switches);
    return (w < 1) ? 1 : w;
  endfunction

  // Only the two deepest sleep modes may cut the chain.
  function automatic logic mode_may_cut(input logic [2:0] mode);
    return (mode == SM_PDOWN) || (mode == SM_PSAVE);
  endfunction

  // A stage is in progress in every state but off and running.
  function automatic logic stage_busy(input stage_e s);
    return (s != ST_OFF) && (s != ST_RUN);
  endfunction

endpackage

// File: rtl/pwr_stage_timer.sv
module pwr_stage_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [CNT_W-1:0] len,
  output logic             done
);
  localparam logic [CNT_W-1:0] ONE = 1;

  logic [CNT_W-1:0] elapsed;
  logic [CNT_W-1:0] last;

  // A zero length behaves as a single cycle.
  assign last = (len == '0) ? '0 : (len - ONE);
  assign done = (elapsed == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       elapsed <= '0;
    else if (restart) elapsed <= '0;
    else              elapsed <= elapsed + ONE;
  end
endmodule

// File: rtl/pwr_bank_picker.sv
module pwr_bank_picker #(
  parameter int NUM_BANKS = 4,
  parameter int IDX_W     = 2
) (
  input  logic [NUM_BANKS-1:0] deselect,
  input  logic [IDX_W-1:0]     from_idx,
  input  logic                 from_start,
  output logic                 found,
  output logic [IDX_W-1:0]     pick_idx
);
  logic [NUM_BANKS-1:0] cand;

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_cand
    if (i == 0) begin : g_first
      assign cand[i] = !deselect[i] && from_start;
    end else begin : g_rest
      assign cand[i] = !deselect[i] && (from_start || (from_idx < IDX_W'(i)));
    end
  end

  // Lowest candidate wins; scan downward so the last hit is the lowest.
  always_comb begin
    found    = 1'b0;
    pick_idx = '0;
    for (int i = NUM_BANKS - 1; i >= 0; i--) begin
      if (cand[i]) begin
        found    = 1'b1;
        pick_idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/pwr_sleep_gate.sv
module pwr_sleep_gate (
  input  logic       in_run,
  input  logic       sleep_en,
  input  logic [2:0] sleep_mode,
  input  logic       radio_off,
  input  logic       radio_sleep,
  output logic       cut_ok
);
  import pwr_chain_pkg::*;

  logic radio_quiet;
  assign radio_quiet = radio_off || radio_sleep;
  assign cut_ok      = in_run && sleep_en && mode_may_cut(sleep_mode) && radio_quiet;
endmodule

// File: rtl/pwr_domain_enables.sv
module pwr_domain_enables #(
  parameter int NUM_BANKS = 4,
  parameter int NUM_PSW   = 3,
  parameter int IDX_W     = 2,
  parameter int RADIO_SW  = 0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  enter,
  input  pwr_chain_pkg::stage_e enter_stage,
  input  logic [IDX_W-1:0]      enter_idx,
  input  logic                  radio_off,
  input  logic                  cut,
  output logic                  ref_en,
  output logic                  reg_en,
  output logic [NUM_BANKS-1:0]  sram_en,
  output logic [NUM_PSW-1:0]    psw_en,
  output logic                  osc_en
);
  import pwr_chain_pkg::*;

  logic [NUM_BANKS-1:0] sram_set;
  logic [NUM_PSW-1:0]   psw_set;

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    assign sram_set[i] = enter && (enter_stage == ST_SRAM) && (enter_idx == IDX_W'(i));
  end

  for (genvar j = 0; j < NUM_PSW; j++) begin : g_psw
    if (j == RADIO_SW) begin : g_radio
      assign psw_set[j] = enter && (enter_stage == ST_PSW) && (enter_idx == IDX_W'(j)) && !radio_off;
    end else begin : g_plain
      assign psw_set[j] = enter && (enter_stage == ST_PSW) && (enter_idx == IDX_W'(j));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_en  <= 1'b0;
      reg_en  <= 1'b0;
      sram_en <= '0;
      psw_en  <= '0;
      osc_en  <= 1'b0;
    end else if (cut) begin
      ref_en  <= 1'b0;
      reg_en  <= 1'b0;
      sram_en <= '0;
      psw_en  <= '0;
      osc_en  <= 1'b0;
    end else begin
      if (enter && (enter_stage == ST_REF)) ref_en <= 1'b1;
      if (enter && (enter_stage == ST_REG)) reg_en <= 1'b1;
      if (enter && (enter_stage == ST_OSC)) osc_en <= 1'b1;
      sram_en <= sram_en | sram_set;
      psw_en  <= psw_en | psw_set;
    end
  end
endmodule

// File: rtl/pwr_chain_seq.sv
module pwr_chain_seq #(
  parameter int NUM_BANKS = 4,
  parameter int NUM_PSW   = 3,
  parameter int CNT_W     = 16,
  parameter int RADIO_SW  = 0,
  localparam int IDX_W    = pwr_chain_pkg::idx_width(NUM_BANKS, NUM_PSW)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wake_req,
  input  logic                 sleep_en,
  input  logic [2:0]           sleep_mode,
  input  logic [NUM_BANKS-1:0] sram_off,
  input  logic                 radio_off,
  input  logic                 radio_sleep,
  input  logic [CNT_W-1:0]     t_por,
  input  logic [CNT_W-1:0]     t_ref,
  input  logic [CNT_W-1:0]     t_reg,
  input  logic [CNT_W-1:0]     t_sram,
  input  logic [CNT_W-1:0]     t_psw,
  input  logic [CNT_W-1:0]     t_osc,
  output logic                 ref_en,
  output logic                 reg_en,
  output logic [NUM_BANKS-1:0] sram_sw_en,
  output logic [NUM_PSW-1:0]   psw_en,
  output logic                 osc_en,
  output logic                 rst_release,
  output logic                 busy,
  output logic [2:0]           stage,
  output logic [IDX_W-1:0]     stage_idx
);
  import pwr_chain_pkg::*;

  localparam logic [IDX_W-1:0] PSW_LAST = IDX_W'(NUM_PSW - 1);
  localparam logic [IDX_W-1:0] IDX_ONE  = 1;

  stage_e           st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [CNT_W-1:0] cur_len;
  logic             stage_done;
  logic             adv;
  logic             cut;
  logic             cut_ok;
  logic             in_run;
  logic             bank_found;
  logic [IDX_W-1:0] bank_idx;

  assign in_run = (st_q == ST_RUN);
  assign cut    = in_run && cut_ok;

  // Length of the stage now being timed.
  always_comb begin
    case (st_q)
      ST_POR:  cur_len = t_por;
      ST_REF:  cur_len = t_ref;
      ST_REG:  cur_len = t_reg;
      ST_SRAM: cur_len = t_sram;
      ST_PSW:  cur_len = t_psw;
      ST_OSC:  cur_len = t_osc;
      default: cur_len = '0;
    endcase
  end

  pwr_stage_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (adv || !stage_busy(st_q)),
    .len     (cur_len),
    .done    (stage_done)
  );

  pwr_bank_picker #(.NUM_BANKS(NUM_BANKS), .IDX_W(IDX_W)) u_picker (
    .deselect   (sram_off),
    .from_idx   (idx_q),
    .from_start (st_q == ST_REG),
    .found      (bank_found),
    .pick_idx   (bank_idx)
  );

  pwr_sleep_gate u_gate (
    .in_run      (in_run),
    .sleep_en    (sleep_en),
    .sleep_mode  (sleep_mode),
    .radio_off   (radio_off),
    .radio_sleep (radio_sleep),
    .cut_ok      (cut_ok)
  );

  // Next stage.
  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    adv   = 1'b0;
    case (st_q)
      ST_OFF: begin
        if (wake_req) begin
          st_d  = ST_REF;
          idx_d = '0;
          adv   = 1'b1;
        end
      end
      ST_RUN: begin
        if (cut_ok) begin
          st_d  = ST_OFF;
          idx_d = '0;
        end
      end
      default: begin
        if (stage_done) begin
          adv = 1'b1;
          case (st_q)
            ST_POR: begin st_d = ST_REF; idx_d = '0; end
            ST_REF: begin st_d = ST_REG; idx_d = '0; end
            ST_REG, ST_SRAM: begin
              if (bank_found) begin
                st_d  = ST_SRAM;
                idx_d = bank_idx;
              end else begin
                st_d  = ST_PSW;
                idx_d = '0;
              end
            end
            ST_PSW: begin
              if (idx_q == PSW_LAST) begin
                st_d  = ST_OSC;
                idx_d = '0;
              end else begin
                idx_d = idx_q + IDX_ONE;
              end
            end
            default: begin st_d = ST_RUN; idx_d = '0; end
          endcase
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_POR;
      idx_q <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
    end
  end

  pwr_domain_enables #(
    .NUM_BANKS (NUM_BANKS),
    .NUM_PSW   (NUM_PSW),
    .IDX_W     (IDX_W),
    .RADIO_SW  (RADIO_SW)
  ) u_enables (
    .clk         (clk),
    .rst_n       (rst_n),
    .enter       (adv),
    .enter_stage (st_d),
    .enter_idx   (idx_d),
    .radio_off   (radio_off),
    .cut         (cut),
    .ref_en      (ref_en),
    .reg_en      (reg_en),
    .sram_en     (sram_sw_en),
    .psw_en      (psw_en),
    .osc_en      (osc_en)
  );

  assign rst_release = in_run;
  assign busy        = stage_busy(st_q);
  assign stage       = st_q;
  assign stage_idx   = idx_q;
endmodule

// File: rtl/pwr_chain_seq_chk.sv
module pwr_chain_seq_chk #(
  parameter int NUM_BANKS = 4,
  parameter int NUM_PSW   = 3,
  parameter int IDX_W     = 2,
  parameter int RADIO_SW  = 0
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wake_req,
  input logic                 sleep_en,
  input logic [2:0]           sleep_mode,
  input logic [NUM_BANKS-1:0] sram_off,
  input logic                 radio_off,
  input logic                 radio_sleep,
  input logic                 ref_en,
  input logic                 reg_en,
  input logic [NUM_BANKS-1:0] sram_sw_en,
  input logic [NUM_PSW-1:0]   psw_en,
  input logic                 osc_en,
  input logic                 rst_release,
  input logic                 busy,
  input logic [2:0]           stage,
  input logic [IDX_W-1:0]     stage_idx,
  input logic                 adv
);
  localparam logic [IDX_W-1:0] LAST_SW = IDX_W'(NUM_PSW - 1);

  // R1
  busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && rst_release));

  // R2
  ref_to_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stage == 3'd2 && adv) |=> (stage == 3'd3));

  // R2
  psw_to_osc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stage == 3'd5 && stage_idx == LAST_SW && adv) |=> (stage == 3'd6));

  // R4
  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank_chk
    bank_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sram_sw_en[i]) |-> !$past(sram_off[i]));
  end

  // R5
  run_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_release |-> (ref_en && reg_en && osc_en));

  // R6
  radio_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(psw_en[RADIO_SW]) |-> !$past(radio_off));

  // R7 R8
  cut_allowed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_release) |-> $past(sleep_en && (sleep_mode == 3'b010 || sleep_mode == 3'b011)
                                 && (radio_off || radio_sleep)));

  // R9
  cut_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_release) |-> (stage == 3'd0 && !busy && !ref_en && !reg_en && !osc_en
                            && sram_sw_en == '0 && psw_en == '0));

  // R10
  wake_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stage == 3'd0 && wake_req) |=> (stage == 3'd2));

  // R11
  run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stage == 3'd7 && !sleep_en) |=> (stage == 3'd7));
endmodule

bind pwr_chain_seq pwr_chain_seq_chk #(
  .NUM_BANKS (NUM_BANKS),
  .NUM_PSW   (NUM_PSW),
  .IDX_W     (IDX_W),
  .RADIO_SW  (RADIO_SW)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wake_req    (wake_req),
  .sleep_en    (sleep_en),
  .sleep_mode  (sleep_mode),
  .sram_off    (sram_off),
  .radio_off   (radio_off),
  .radio_sleep (radio_sleep),
  .ref_en      (ref_en),
  .reg_en      (reg_en),
  .sram_sw_en  (sram_sw_en),
  .psw_en      (psw_en),
  .osc_en      (osc_en),
  .rst_release (rst_release),
  .busy        (busy),
  .stage       (stage),
  .stage_idx   (stage_idx),
  .adv         (adv)
);

// File: tb/test_pwr_chain_seq.sv
`timescale 1ns/1ps
module test_pwr_chain_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wake_req = 1'b0;
  logic        sleep_en = 1'b0;
  logic [2:0]  sleep_mode = 3'b000;
  logic [3:0]  sram_off = 4'b0000;
  logic        radio_off = 1'b0;
  logic        radio_sleep = 1'b0;
  logic [15:0] t_por = 16'd5, t_ref = 16'd3, t_reg = 16'd4;
  logic [15:0] t_sram = 16'd2, t_psw = 16'd3, t_osc = 16'd6;
  logic        ref_en, reg_en, osc_en, rst_release, busy;
  logic [3:0]  sram_sw_en;
  logic [2:0]  psw_en;
  logic [2:0]  stage;
  logic [1:0]  stage_idx;

  int  total = 0;
  int  bad = 0;
  bit  finished = 1'b0;

  always #2.5 clk = ~clk;

  pwr_chain_seq i_pwr_chain_seq (
    .clk(clk), .rst_n(rst_n), .wake_req(wake_req), .sleep_en(sleep_en),
    .sleep_mode(sleep_mode), .sram_off(sram_off), .radio_off(radio_off),
    .radio_sleep(radio_sleep), .t_por(t_por), .t_ref(t_ref), .t_reg(t_reg),
    .t_sram(t_sram), .t_psw(t_psw), .t_osc(t_osc), .ref_en(ref_en),
    .reg_en(reg_en), .sram_sw_en(sram_sw_en), .psw_en(psw_en), .osc_en(osc_en),
    .rst_release(rst_release), .busy(busy), .stage(stage), .stage_idx(stage_idx)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int eff(input logic [15:0] t);
    return (t == 16'd0) ? 1 : int'(t);
  endfunction

  function automatic int kept(input logic [3:0] mask);
    int c = 0;
    for (int b = 0; b < 4; b++) if (!mask[b]) c++;
    return c;
  endfunction

  // Run one startup, cold (through reset) or warm (through wake_req).
  // poke: pulse wake and sleep requests mid-startup (R11).
  task automatic run_chain(input bit cold, input logic [3:0] mask, input bit poke);
    logic [4:0] exp_seq[16];
    int ne = 0, pos = 0, n = 0, expect_n;
    bit order_ok = 1'b1, busy_ok = 1'b1;
    logic [4:0] prev, cur;
    sram_off = mask;
    if (cold) exp_seq[ne++] = {3'd1, 2'd0};
    exp_seq[ne++] = {3'd2, 2'd0};
    exp_seq[ne++] = {3'd3, 2'd0};
    for (int b = 0; b < 4; b++) if (!mask[b]) exp_seq[ne++] = {3'd4, 2'(b)};
    for (int p = 0; p < 3; p++) exp_seq[ne++] = {3'd5, 2'(p)};
    exp_seq[ne++] = {3'd6, 2'd0};
    exp_seq[ne++] = {3'd7, 2'd0};
    expect_n = eff(t_ref) + eff(t_reg) + kept(mask) * eff(t_sram) + 3 * eff(t_psw) + eff(t_osc)
             + (cold ? eff(t_por) : 1);
    if (cold) begin
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); @(negedge clk);
      // R1 reset state
      chk(stage == 3'd1, "R1", "stage in reset", stage, 1);
      chk(busy && !rst_release, "R1", "busy/release in reset", {busy, rst_release}, 2);
      chk({ref_en, reg_en, sram_sw_en, psw_en, osc_en} == '0, "R1", "enables in reset",
          {ref_en, reg_en, sram_sw_en, psw_en, osc_en}, 0);
      rst_n = 1'b1;
      prev = {3'd1, 2'd0};
      pos = 1;
    end else begin
      @(negedge clk);
      wake_req = 1'b1;
      prev = {3'd0, 2'd0};
    end
    do begin
      @(negedge clk);
      n++;
      if (!cold && n == 1) wake_req = 1'b0;
      if (poke && n == 4) begin
        wake_req = 1'b1; sleep_en = 1'b1; sleep_mode = 3'b010; radio_sleep = 1'b1;
      end
      if (poke && n == 6) begin
        wake_req = 1'b0; sleep_en = 1'b0; radio_sleep = 1'b0;
      end
      cur = {stage, stage_idx};
      if (cur != prev) begin
        if (pos >= ne || cur != exp_seq[pos]) order_ok = 1'b0;
        pos++;
        prev = cur;
      end
      if (!rst_release && !busy) busy_ok = 1'b0;
    end while (!rst_release && n < 2000);
    chk(order_ok && pos == ne, "R2", "stage order", pos, ne);
    chk(busy_ok, "R1", "busy during startup", busy_ok, 1);
    chk(n == expect_n, cold ? "R3" : "R10", "startup edges", n, expect_n);
    chk(sram_sw_en == ~mask, "R4", "bank enables", sram_sw_en, ~mask);
    chk(psw_en == (radio_off ? 3'b110 : 3'b111), "R6", "switch enables", psw_en,
        radio_off ? 3'b110 : 3'b111);
    chk(ref_en && reg_en && osc_en && !busy, "R5", "domain enables at run",
        {ref_en, reg_en, osc_en, busy}, 14);
    if (poke) chk(n == expect_n && stage == 3'd7, "R11", "pulses during startup ignored", n, expect_n);
  endtask

  // One sleep attempt from the running state.
  task automatic try_sleep(input logic [2:0] mode, input bit roff, input bit rsl, input bit want_cut);
    @(negedge clk);
    sleep_mode = mode; radio_off = roff; radio_sleep = rsl; sleep_en = 1'b1;
    @(negedge clk);
    if (want_cut) begin
      chk(stage == 3'd0 && !busy && !rst_release, "R9", "cut state", stage, 0);
      chk({ref_en, reg_en, sram_sw_en, psw_en, osc_en} == '0, "R9", "all enables dropped",
          {ref_en, reg_en, sram_sw_en, psw_en, osc_en}, 0);
      chk(1'b1, (roff || rsl) ? "R8" : "R7", "cut allowed", 1, 1);
    end else begin
      chk(stage == 3'd7 && rst_release, (mode == 3'b010 || mode == 3'b011) ? "R8" : "R7",
          "chain kept on", stage, 7);
    end
    sleep_en = 1'b0; radio_sleep = 1'b0;
    @(negedge clk);
  endtask

  task automatic wake_in_run;
    @(negedge clk); wake_req = 1'b1;
    @(negedge clk); @(negedge clk); wake_req = 1'b0;
    chk(stage == 3'd7 && rst_release && !busy, "R11", "wake while running", stage, 7);
  endtask

  initial begin
    radio_off = 1'b0;
    run_chain(1'b1, 4'b0000, 1'b0);          // R3 all banks
    for (int m = 0; m < 8; m++) begin
      if (m != 2 && m != 3) try_sleep(3'(m), 1'b0, 1'b1, 1'b0);  // R7 other modes
    end
    try_sleep(3'b010, 1'b0, 1'b0, 1'b0);     // R8 active radio blocks the cut
    try_sleep(3'b011, 1'b0, 1'b0, 1'b0);
    wake_in_run();
    try_sleep(3'b010, 1'b0, 1'b1, 1'b1);     // R8 radio asleep
    run_chain(1'b0, 4'b0101, 1'b0);          // R10 R4
    try_sleep(3'b011, 1'b1, 1'b0, 1'b1);     // R8 radio deselected
    run_chain(1'b0, 4'b1111, 1'b0);          // R6 radio stays off, no banks
    radio_off = 1'b0;
    try_sleep(3'b011, 1'b0, 1'b1, 1'b1);
    run_chain(1'b0, 4'b0000, 1'b1);          // R11 pulses during startup
    t_osc = 16'd0;                           // R3 zero count acts as one
    try_sleep(3'b010, 1'b0, 1'b1, 1'b1);
    run_chain(1'b0, 4'b1000, 1'b0);
    t_osc = 16'd6;
    radio_off = 1'b1;
    run_chain(1'b1, 4'b1010, 1'b0);          // R6 cold with radio deselected
    radio_off = 1'b0;
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule